// File: doc/BRIEF.md
# Single-Precision Special-Value Conditioner

This stage wraps a single-precision arithmetic datapath. It sees the two operands going in and the result coming out. It sorts each operand into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. It then rewrites the three values according to two mode inputs.

With flushing enabled, denormals become zeros of the same sign. With the canonical-NaN mode enabled, any NaN, on an operand or on the result, becomes one fixed quiet NaN. Without that mode, a signaling NaN is only quieted.

All outputs are registered. They appear one cycle after a valid input, together with one-cycle event pulses that a status register can collect: one pulse when a denormal was flushed, one when a signaling NaN was seen at an operand.

Top module: `fp_special_cond`

## Requirements
- R1: Value layout is sign at bit 31, exponent at bits 30:23 and fraction at bits 22:0. The fraction MSB (bit 22) is the quiet bit. The class codes on `class_a` and `class_b` are 0 zero, 1 denormal, 2 normal, 3 infinity, 4 quiet NaN and 5 signaling NaN.
- R2: `out_valid` is high in exactly the cycle after `in_valid` was high. Classes, conditioned values and events belong to that input. While `out_valid` is low, both event outputs are low.
- R3: Zeros, normals and infinities pass unchanged, and so do denormals when flushing is off.
- R4: With `flush_en` high, a denormal operand or result is replaced by a zero that keeps the original sign bit.
- R5: `evt_flush` pulses exactly when `flush_en` was high and at least one of the operands or the result was denormal.
- R6: With `dnan_en` high, each NaN value is replaced by 0x7FC00000. The result output is also replaced by 0x7FC00000 when either operand is a NaN.
- R7: With `dnan_en` low, a signaling NaN leaves with bit 22 set and all other bits kept. A quiet NaN is unchanged, and an operand NaN does not alter the result.
- R8: `evt_invalid` pulses exactly when operand A or operand B was a signaling NaN. A signaling NaN on the result does not raise it.
- R9: After reset, `out_valid`, both events, all conditioned values and both class codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs below are valid this cycle |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| res_in | input | 32 | Datapath result |
| flush_en | input | 1 | Flush denormals to signed zero |
| dnan_en | input | 1 | Replace NaNs with the canonical quiet NaN |
| out_valid | output | 1 | Registered outputs are valid |
| cond_a | output | 32 | Conditioned operand A |
| cond_b | output | 32 | Conditioned operand B |
| cond_res | output | 32 | Conditioned result |
| class_a | output | 3 | Class code of operand A |
| class_b | output | 3 | Class code of operand B |
| evt_flush | output | 1 | Denormal-flushed event pulse |
| evt_invalid | output | 1 | Signaling-NaN-operand event pulse |

## Verification
The bench builds the block with its default widths of 8 exponent bits and 23 fraction bits. At those widths the quiet bit sits at bit 22 and the canonical NaN is the 32-bit pattern 0x7FC00000, so every expected value can be written as a literal hex word. These widths also bring the extreme encodings within reach: the smallest and largest denormals, negative zero, negative infinity, and NaNs with only their lowest fraction bit set. With them, the bench probes every class boundary and the interplay of the two modes on the result lane.

// File: rtl/fpsc_pkg.sv
// Shared types for the special-value conditioner.
// Assumes nothing beyond a 3-bit class code.
package fpsc_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5
    } fp_class_e;
endpackage

// File: rtl/fpsc_classify.sv
// Combinational classifier for one IEEE-style binary value.
// Assumes the layout {sign, exponent, fraction}, with the quiet bit at the fraction MSB.
module fpsc_classify
    import fpsc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output fp_class_e             cls
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = val[W-2 -: EXP_W];
    assign frac = val[FRAC_W-1:0];

    // Decode exponent and fraction into one of six classes.
    always_comb begin
        if (expo == '0) begin
            cls = (frac == '0) ? CLS_ZERO : CLS_DENORM;
        end else if (&expo) begin
            if (frac == '0)
                cls = CLS_INF;
            else
                cls = frac[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        end else begin
            cls = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/fpsc_condition.sv
// Rewrites one value according to its class and the two mode bits.
// Assumes cls was computed from val. force_nan lets a neighbour lane
// (an operand NaN) force the canonical NaN on this lane in canonical mode.
module fpsc_condition
    import fpsc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] val,
    input  fp_class_e             cls,
    input  logic                  ftz,
    input  logic                  dn,
    input  logic                  force_nan,
    output logic [EXP_W+FRAC_W:0] cond,
    output logic                  flushed
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic is_nan;

    assign is_nan  = (cls == CLS_QNAN) || (cls == CLS_SNAN);
    assign flushed = ftz && (cls == CLS_DENORM);

    // Pick canonical NaN, quieted NaN, signed zero or pass-through.
    always_comb begin
        cond = val;
        if (dn && (is_nan || force_nan))
            cond = CANON_NAN;
        else if (is_nan)
            cond[FRAC_W-1] = 1'b1;
        else if (flushed)
            cond = {val[W-1], {(W-1){1'b0}}};
    end
endmodule

// File: rtl/fp_special_cond.sv
// Special-value conditioner around a floating-point datapath.
// Lanes 0 and 1 carry the operands and lane 2 the result. The lanes are
// classified and conditioned combinationally, then registered once.
// Assumes the result on res_in belongs to the operands of the same cycle.
module fp_special_cond
    import fpsc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] res_in,
    input  logic                  flush_en,
    input  logic                  dnan_en,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] cond_a,
    output logic [EXP_W+FRAC_W:0] cond_b,
    output logic [EXP_W+FRAC_W:0] cond_res,
    output logic [2:0]            class_a,
    output logic [2:0]            class_b,
    output logic                  evt_flush,
    output logic                  evt_invalid
);
    localparam int W        = 1 + EXP_W + FRAC_W;
    localparam int N_LANE   = 3;
    localparam int LANE_RES = N_LANE - 1;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0]      lane_val  [N_LANE];
    logic [W-1:0]      lane_cond [N_LANE];
    fp_class_e         lane_cls  [N_LANE];
    logic [N_LANE-1:0] lane_flush;
    logic [N_LANE-1:0] lane_force;
    logic              opnd_nan;
    logic              opnd_snan;

    assign lane_val[0]        = op_a;
    assign lane_val[1]        = op_b;
    assign lane_val[LANE_RES] = res_in;

    // An operand NaN propagates to the result lane in canonical mode.
    always_comb begin
        opnd_nan  = 1'b0;
        opnd_snan = 1'b0;
        for (int i = 0; i < LANE_RES; i++) begin
            opnd_nan  = opnd_nan  | (lane_cls[i] == CLS_QNAN) | (lane_cls[i] == CLS_SNAN);
            opnd_snan = opnd_snan | (lane_cls[i] == CLS_SNAN);
        end
        lane_force           = '0;
        lane_force[LANE_RES] = opnd_nan;
    end

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        fpsc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .val (lane_val[g]),
            .cls (lane_cls[g])
        );
        fpsc_condition #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cond (
            .val       (lane_val[g]),
            .cls       (lane_cls[g]),
            .ftz       (flush_en),
            .dn        (dnan_en),
            .force_nan (lane_force[g]),
            .cond      (lane_cond[g]),
            .flushed   (lane_flush[g])
        );
    end

    // Output register: data loads on valid, events pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            evt_flush   <= 1'b0;
            evt_invalid <= 1'b0;
            cond_a      <= '0;
            cond_b      <= '0;
            cond_res    <= '0;
            class_a     <= '0;
            class_b     <= '0;
        end else begin
            out_valid   <= in_valid;
            evt_flush   <= in_valid && (|lane_flush);
            evt_invalid <= in_valid && opnd_snan;
            if (in_valid) begin
                cond_a   <= lane_cond[0];
                cond_b   <= lane_cond[1];
                cond_res <= lane_cond[LANE_RES];
                class_a  <= lane_cls[0];
                class_b  <= lane_cls[1];
            end
        end
    end

    // R2: valid follows input by one cycle
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2: no event without valid output
    assert_event_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!evt_flush && !evt_invalid));

    // R1: class codes stay in the legal range
    assert_class_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (class_a <= 3'd5 && class_b <= 3'd5));

    // R4: a flushed denormal operand is a zero with its own sign
    assert_flush_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(flush_en) && class_a == 3'd1)
        |-> (cond_a[W-2:0] == '0 && cond_a[W-1] == $past(op_a[W-1])));

    // R6: canonical mode turns a NaN operand into the canonical NaN on every NaN lane
    assert_canon_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(dnan_en) && class_b >= 3'd4)
        |-> (cond_b == CANON_NAN && cond_res == CANON_NAN));

    // R8: the invalid event needs a signaling NaN operand
    assert_invalid_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_invalid |-> (class_a == 3'd5 || class_b == 3'd5));
endmodule

// File: tb/test_fp_special_cond.sv
module test_fp_special_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, res_in = '0;
    logic        flush_en = 1'b0, dnan_en = 1'b0;
    logic        out_valid, evt_flush, evt_invalid;
    logic [31:0] cond_a, cond_b, cond_res;
    logic [2:0]  class_a, class_b;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] CNAN = 32'h7FC0_0000;

    always #10 clk = ~clk;

    fp_special_cond i_fp_special_cond (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .res_in(res_in),
        .flush_en(flush_en), .dnan_en(dnan_en),
        .out_valid(out_valid), .cond_a(cond_a), .cond_b(cond_b),
        .cond_res(cond_res), .class_a(class_a), .class_b(class_b),
        .evt_flush(evt_flush), .evt_invalid(evt_invalid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive one vector at a falling edge and sample at the next falling edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] r, input logic ftz, input logic dn);
        op_a = a; op_b = b; res_in = r;
        flush_en = ftz; dnan_en = dn; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "out_valid", {31'b0, out_valid}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R9", "out_valid", {31'b0, out_valid}, 32'd0);
        chk("R9", "evt_flush", {31'b0, evt_flush}, 32'd0);
        chk("R9", "evt_invalid", {31'b0, evt_invalid}, 32'd0);
        chk("R9", "cond_res", cond_res, 32'd0);
        chk("R9", "class_a", {29'b0, class_a}, 32'd0);
    endtask

    task automatic t_zero_denorm_pass;
        apply(32'h8000_0000, 32'h0000_0001, 32'h3F80_0000, 1'b0, 1'b0);
        chk("R1", "class_a negzero", {29'b0, class_a}, 32'd0);
        chk("R1", "class_b denorm", {29'b0, class_b}, 32'd1);
        chk("R3", "cond_a", cond_a, 32'h8000_0000);
        chk("R3", "cond_b denorm kept", cond_b, 32'h0000_0001);
        chk("R3", "cond_res", cond_res, 32'h3F80_0000);
        chk("R5", "evt_flush off", {31'b0, evt_flush}, 32'd0);
    endtask

    task automatic t_normal_inf;
        apply(32'h3F80_0000, 32'hFF80_0000, 32'h7F80_0000, 1'b1, 1'b1);
        chk("R1", "class_a normal", {29'b0, class_a}, 32'd2);
        chk("R1", "class_b inf", {29'b0, class_b}, 32'd3);
        chk("R3", "cond_b inf", cond_b, 32'hFF80_0000);
        chk("R3", "cond_res inf", cond_res, 32'h7F80_0000);
        chk("R8", "no invalid", {31'b0, evt_invalid}, 32'd0);
    endtask

    task automatic t_nan_quiet;
        apply(32'hFFC0_0001, 32'h7F80_0001, 32'h3F80_0000, 1'b0, 1'b0);
        chk("R1", "class_a qnan", {29'b0, class_a}, 32'd4);
        chk("R1", "class_b snan", {29'b0, class_b}, 32'd5);
        chk("R7", "qnan kept", cond_a, 32'hFFC0_0001);
        chk("R7", "snan quieted", cond_b, 32'h7FC0_0001);
        chk("R7", "result untouched", cond_res, 32'h3F80_0000);
        chk("R8", "invalid on snan", {31'b0, evt_invalid}, 32'd1);
    endtask

    task automatic t_flush_all;
        apply(32'h8000_0005, 32'h0040_0000, 32'h807F_FFFF, 1'b1, 1'b0);
        chk("R4", "neg denorm a", cond_a, 32'h8000_0000);
        chk("R4", "pos denorm b", cond_b, 32'h0000_0000);
        chk("R4", "neg denorm res", cond_res, 32'h8000_0000);
        chk("R5", "flush event", {31'b0, evt_flush}, 32'd1);
    endtask

    task automatic t_flush_result_only;
        apply(32'h4000_0000, 32'h4040_0000, 32'h0000_0003, 1'b1, 1'b0);
        chk("R4", "res flushed", cond_res, 32'h0000_0000);
        chk("R5", "flush from result", {31'b0, evt_flush}, 32'd1);
        apply(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, 1'b1, 1'b0);
        chk("R5", "no denorm no event", {31'b0, evt_flush}, 32'd0);
    endtask

    task automatic t_default_nan;
        apply(32'hFFC1_2345, 32'h4000_0000, 32'h4000_0000, 1'b0, 1'b1);
        chk("R6", "qnan a canon", cond_a, CNAN);
        chk("R6", "b normal kept", cond_b, 32'h4000_0000);
        chk("R6", "res forced by operand", cond_res, CNAN);
        chk("R8", "qnan not invalid", {31'b0, evt_invalid}, 32'd0);
        apply(32'h4000_0000, 32'h4000_0000, 32'hFF80_0001, 1'b0, 1'b1);
        chk("R6", "snan result canon", cond_res, CNAN);
        chk("R8", "result snan not invalid", {31'b0, evt_invalid}, 32'd0);
        apply(32'h3F80_0000, 32'hFFBF_FFFF, 32'h3F80_0000, 1'b0, 1'b1);
        chk("R6", "snan b canon", cond_b, CNAN);
        chk("R8", "snan b invalid", {31'b0, evt_invalid}, 32'd1);
    endtask

    task automatic t_idle;
        op_a = 32'h7F80_0001; op_b = 32'h0000_0001; res_in = 32'h0000_0001;
        flush_en = 1'b1; dnan_en = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R2", "idle evt_flush", {31'b0, evt_flush}, 32'd0);
        chk("R2", "idle evt_invalid", {31'b0, evt_invalid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_zero_denorm_pass();
        t_normal_inf();
        t_nan_quiet();
        t_flush_all();
        t_flush_result_only();
        t_default_nan();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule